// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address. It holds four 16-bit segment bases: code, data, stack and extra. A requester presents an access kind, an offset and a valid strobe. The access kind selects the segment implicitly. The block shifts the selected base left by four bits, fills the vacated bits with zeros and adds the offset. Any carry beyond the top address bit is dropped, so addresses wrap within a 1 MB space. One clock later the result appears, together with the index of the segment that was used.

The segment bases are written through a separate load port. Reset places the code segment at the top of the space so that the first fetch lands 16 bytes below the wrap point. Decoding instructions, override prefixes and the pointer registers that produce the offsets belong to the surrounding logic.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted and directly after it, `pa_valid` is 0 and `pa_addr` is 0. Reset sets the code base to 0xFFFF and the data, stack and extra bases to 0x0000, so a fetch with offset 0x0000 yields 0xFFFF0.
- R2: The physical address equals (base << 4) + offset, for example base 0xA4FB with offset 0x4872 gives 0xA9822.
- R3: A carry out of bit 19 is discarded. Base 0xFFFF with offset 0x0010 gives 0x00000, and with offset 0xFFFF it gives 0x0FFEF.
- R4: The access kind selects the segment, and the segment index is reported on `pa_seg`. Kind 0 (instruction fetch) uses code, index 0. Kind 1 (data) uses data, index 1. Kind 2 (string destination) uses extra, index 3. Kind 3 (stack pointer) and kind 4 (frame pointer) use stack, index 2.
- R5: `pa_valid` rises exactly one clock after a cycle with `req_valid` high, and `pa_addr` and `pa_seg` for that request appear in the same cycle.
- R6: After a cycle with `req_valid` low, `pa_valid` is 0 and `pa_addr` and `pa_seg` keep their previous values.
- R7: With `ld_en` high, the base chosen by `ld_sel` (same index encoding as R4) takes `ld_val` at the clock edge. A request in that same cycle still uses the old base, and requests from the next cycle on use the new one.
- R8: A load leaves the other three bases unchanged.
- R9: Access kinds 5, 6 and 7 are reserved and use the data segment (index 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 3 | Access kind code |
| req_ofs | input | 16 | Offset within the segment |
| ld_en | input | 1 | Segment base write enable |
| ld_sel | input | 2 | Index of the base to write |
| ld_val | input | 16 | New base value |
| pa_valid | output | 1 | Result valid, one cycle after the request |
| pa_addr | output | 20 | Physical address |
| pa_seg | output | 2 | Index of the segment used |

## Verification
The main function is driven with each of the eight access kinds against four bases that differ from one another. A wrong segment choice therefore produces a different address as well as a different index. Offsets include zero, all ones, values with the low nibble set and values with the high bit set. The all-ones stack base paired with large offsets separates correct wraparound from a 21-bit or saturating sum. A low-nibble-only offset shows whether the base was shifted rather than added flat. A load issued in the same cycle as a request tells apart old-base and new-base forwarding. A data request made after a code-base load shows whether the load leaked into the other bases.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int N_SEG      = 4;
    localparam int SEG_IDX_W  = 2;
    localparam int KIND_W     = 3;

    // Segment index encoding, visible on pa_seg and ld_sel
    typedef enum logic [SEG_IDX_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_idx_e;

    // Access kind encoding; 5..7 reserved
    typedef enum logic [KIND_W-1:0] {
        ACC_FETCH     = 3'd0,
        ACC_DATA      = 3'd1,
        ACC_STR_DST   = 3'd2,
        ACC_STACK_PTR = 3'd3,
        ACC_FRAME_PTR = 3'd4
    } acc_kind_e;

endpackage

// File: rtl/seg_bank.sv
module seg_bank
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [SEG_IDX_W-1:0] ld_sel,
    input  logic [SEG_W-1:0]     ld_val,
    output logic [SEG_W-1:0]     seg_o [N_SEG]
);

    logic [SEG_W-1:0] seg_d [N_SEG];
    logic [SEG_W-1:0] seg_q [N_SEG];

    always_comb begin
        for (int i = 0; i < N_SEG; i++) begin
            seg_d[i] = seg_q[i];
        end
        if (ld_en) begin
            seg_d[ld_sel] = ld_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SEG; i++) begin
                // code base starts at all ones, the others at zero
                seg_q[i] <= (i == int'(SEG_CODE)) ? '1 : '0;
            end
        end else begin
            for (int i = 0; i < N_SEG; i++) begin
                seg_q[i] <= seg_d[i];
            end
        end
    end

    assign seg_o = seg_q;

    generate
        for (genvar g = 0; g < N_SEG; g++) begin : g_chk
            assert_load_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (ld_en && ld_sel == g[SEG_IDX_W-1:0]) |=> (seg_q[g] == $past(ld_val)));
            assert_others_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !(ld_en && ld_sel == g[SEG_IDX_W-1:0]) |=> $stable(seg_q[g]));
        end
    endgenerate

endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_addr_pkg::*;
(
    input  logic [KIND_W-1:0] kind_i,
    output seg_idx_e          idx_o
);

    always_comb begin
        case (kind_i)
            ACC_FETCH:     idx_o = SEG_CODE;
            ACC_DATA:      idx_o = SEG_DATA;
            ACC_STR_DST:   idx_o = SEG_EXTRA;
            ACC_STACK_PTR: idx_o = SEG_STACK;
            ACC_FRAME_PTR: idx_o = SEG_STACK;
            default:       idx_o = SEG_DATA;   // reserved kinds (R9)
        endcase
    end

endmodule

// File: rtl/seg_shift_add.sv
module seg_shift_add #(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] base_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic [PA_W-1:0]  addr_o
);

    logic [PA_W-1:0] base_ext;
    logic [PA_W-1:0] ofs_ext;

    generate
        if (SHIFT > 0) begin : g_shift
            assign base_ext = {base_i, {SHIFT{1'b0}}};
        end else begin : g_flat
            assign base_ext = base_i;
        end
        if (OFS_W < PA_W) begin : g_pad
            assign ofs_ext = {{(PA_W-OFS_W){1'b0}}, ofs_i};
        end else begin : g_nopad
            assign ofs_ext = ofs_i[PA_W-1:0];
        end
    endgenerate

    // sum truncated to PA_W: carry out is dropped (R3)
    assign addr_o = base_ext + ofs_ext;

    generate
        if (SHIFT > 0) begin : g_lowchk
            always_comb begin
                assert_low_bits_R2: assert (addr_o[SHIFT-1:0] == ofs_i[SHIFT-1:0]);
            end
        end
    endgenerate

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [KIND_W-1:0]    req_kind,
    input  logic [OFS_W-1:0]     req_ofs,
    input  logic                 ld_en,
    input  logic [SEG_IDX_W-1:0] ld_sel,
    input  logic [SEG_W-1:0]     ld_val,
    output logic                 pa_valid,
    output logic [SEG_W+SHIFT-1:0] pa_addr,
    output logic [SEG_IDX_W-1:0] pa_seg
);

    localparam int PA_W = SEG_W + SHIFT;

    typedef struct packed {
        logic                 vld;
        logic [PA_W-1:0]      addr;
        logic [SEG_IDX_W-1:0] seg;
    } out_s;

    logic [SEG_W-1:0] bases [N_SEG];
    seg_idx_e         sel_idx;
    logic [PA_W-1:0]  sum_addr;
    out_s             out_d;
    out_s             out_q;

    seg_bank #(.SEG_W(SEG_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (ld_en),
        .ld_sel (ld_sel),
        .ld_val (ld_val),
        .seg_o  (bases)
    );

    seg_select u_sel (
        .kind_i (req_kind),
        .idx_o  (sel_idx)
    );

    seg_shift_add #(
        .SEG_W (SEG_W),
        .OFS_W (OFS_W),
        .SHIFT (SHIFT),
        .PA_W  (PA_W)
    ) u_add (
        .base_i (bases[sel_idx]),
        .ofs_i  (req_ofs),
        .addr_o (sum_addr)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = req_valid;
        if (req_valid) begin
            out_d.addr = sum_addr;
            out_d.seg  = sel_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pa_valid = out_q.vld;
    assign pa_addr  = out_q.addr;
    assign pa_seg   = out_q.seg;

    assert_valid_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> pa_valid);
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!pa_valid && $stable(pa_addr) && $stable(pa_seg)));
    assert_fetch_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == ACC_FETCH) |=> (pa_seg == SEG_CODE));
    assert_reserved_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind > ACC_FRAME_PTR) |=> (pa_seg == SEG_DATA));

endmodule

// File: tb/seg_addr_gen_tb_top.sv
`timescale 1ns/1ps
module seg_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_ofs = '0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [15:0] ld_val = '0;
    logic        pa_valid;
    logic [19:0] pa_addr;
    logic [1:0]  pa_seg;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    seg_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_ofs(req_ofs), .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
        .pa_valid(pa_valid), .pa_addr(pa_addr), .pa_seg(pa_seg)
    );

    // {kind, offset, expected address, expected segment}
    // bases: code A4FB, data 1000, stack FFFF, extra 0800
    localparam int NV = 9;
    localparam logic [40:0] VEC [NV] = '{
        {3'd0, 16'h4872, 20'hA9822, 2'd0},
        {3'd1, 16'h0234, 20'h10234, 2'd1},
        {3'd2, 16'hFFFF, 20'h17FFF, 2'd3},
        {3'd3, 16'h0010, 20'h00000, 2'd2},
        {3'd4, 16'hFFFF, 20'h0FFEF, 2'd2},
        {3'd5, 16'h0001, 20'h10001, 2'd1},
        {3'd6, 16'h8000, 20'h18000, 2'd1},
        {3'd7, 16'h0000, 20'h10000, 2'd1},
        {3'd0, 16'hB78F, 20'hB073F, 2'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] k, input logic [15:0] o);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_ofs = o;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic load(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = s; ld_val = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid in reset", 32'(pa_valid), 32'd0);
        chk("R1 addr in reset", 32'(pa_addr), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 32'(pa_valid), 32'd0);
        // R1: first fetch at FFFF0
        issue(3'd0, 16'h0000);
        chk("R1 first fetch addr", 32'(pa_addr), 32'hFFFF0);
        chk("R5 valid after request", 32'(pa_valid), 32'd1);
        chk("R4 fetch seg", 32'(pa_seg), 32'd0);
        // R6: idle cycle holds
        @(negedge clk);
        chk("R6 valid low when idle", 32'(pa_valid), 32'd0);
        chk("R6 addr held", 32'(pa_addr), 32'hFFFF0);
        chk("R6 seg held", 32'(pa_seg), 32'd0);
        // R7: load and request in the same cycle use the old base
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 2'd0; ld_val = 16'hA4FB;
        req_valid = 1'b1; req_kind = 3'd0; req_ofs = 16'h4872;
        @(negedge clk);
        ld_en = 1'b0; req_valid = 1'b0;
        chk("R7 same-cycle old base", 32'(pa_addr), 32'h04862);
        issue(3'd0, 16'h4872);
        chk("R7 new base used", 32'(pa_addr), 32'hA9822);
        // R8: data base untouched by code load
        issue(3'd1, 16'h0000);
        chk("R8 data base unchanged", 32'(pa_addr), 32'h00000);
        chk("R8 data seg", 32'(pa_seg), 32'd1);
        issue(3'd3, 16'h0044);
        chk("R8 stack base unchanged", 32'(pa_addr), 32'h00044);
        // table bases
        load(2'd1, 16'h1000);
        load(2'd2, 16'hFFFF);
        load(2'd3, 16'h0800);
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][40:38], VEC[i][37:22]);
            // R2 R3 address, R4 R9 segment, R5 valid
            chk($sformatf("R2/R3 addr vec %0d", i), 32'(pa_addr), 32'(VEC[i][21:2]));
            chk($sformatf("R4/R9 seg vec %0d", i), 32'(pa_seg), 32'(VEC[i][1:0]));
            chk($sformatf("R5 valid vec %0d", i), 32'(pa_valid), 32'd1);
        end
        // R3: explicit wrap corner on the all-ones stack base
        issue(3'd4, 16'h0011);
        chk("R3 wrap just past top", 32'(pa_addr), 32'h00001);
        finish_run();
    end

endmodule